// File: doc/BRIEF.md
# Pooled Transmit/Receive Word Queue Pair

This block holds two first-in first-out word queues between a host and a processing engine. The transmit queue carries words from the host to the engine, and the receive queue carries words from the engine back to the host. Both queues live in one shared storage array of twice the base depth. In split mode each queue owns half of that array. Either queue can be told to borrow the other half and so hold twice as many words. The queue that gives up its half is then disabled: it has zero capacity and reports itself empty and full at the same time.

For each direction the block reports empty, full and an occupancy count. The engine side shows a stall strobe in the same cycle whenever it tries to take from an empty transmit queue or add to a full receive queue. Four sticky debug bits record engine stalls, host writes that were dropped, and host reads that found nothing. The host clears these bits by writing ones to them.

Top module: `fifo_join_pair`

## Requirements
- R1: After reset both empty outputs are 1, both full outputs are 0, both levels are 0 and all four debug bits are 0.
- R2: With both join inputs low, each queue holds 4 words in arrival order. Its full output rises when the level reaches 4.
- R3: With joinTx high, the transmit queue holds 8 words in order. The receive queue is disabled: rxEmpty=1, rxFull=1, rxLevel=0.
- R4: With only joinRx high, the receive queue holds 8 words in order and the transmit queue is disabled in the same way. When both join inputs are high, joinTx takes effect.
- R5: The level outputs are 4 bits wide and equal the number of stored words. A push and a pop accepted in the same cycle leave the level unchanged.
- R6: A host push to a full transmit queue is dropped and sets debug bit 1 (overflow).
- R7: A host pop from an empty receive queue returns zero on hostRxData, leaves the queue unchanged and sets debug bit 2 (underflow).
- R8: An engine pop from an empty transmit queue raises engTxStall in that cycle, returns zero on engTxData and sets debug bit 0.
- R9: An engine push to a full receive queue raises engRxStall in that cycle, is dropped and sets debug bit 3.
- R10: A 1 on a dbgClear bit clears that debug bit at the next edge, and a 0 leaves it alone. If the same bit is set and cleared in one cycle, the set wins.
- R11: A change in the effective join mode empties both queues at the next edge. Pushes and pops presented in that cycle have no effect on the queues.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| joinTx | input | 1 | Transmit queue takes the whole storage |
| joinRx | input | 1 | Receive queue takes the whole storage |
| hostTxPush | input | 1 | Host writes a word into the transmit queue |
| hostTxData | input | DATA_W | Word written by the host |
| hostRxPop | input | 1 | Host reads a word from the receive queue |
| hostRxData | output | DATA_W | Head of the receive queue while popping, else zero |
| engTxPop | input | 1 | Engine takes a word from the transmit queue |
| engTxData | output | DATA_W | Head of the transmit queue while popping, else zero |
| engTxStall | output | 1 | Engine pop met an empty transmit queue |
| engRxPush | input | 1 | Engine writes a word into the receive queue |
| engRxData | input | DATA_W | Word written by the engine |
| engRxStall | output | 1 | Engine push met a full receive queue |
| txEmpty | output | 1 | Transmit queue holds no words |
| txFull | output | 1 | Transmit queue is at capacity |
| rxEmpty | output | 1 | Receive queue holds no words |
| rxFull | output | 1 | Receive queue is at capacity |
| txLevel | output | LVL_W | Transmit queue occupancy |
| rxLevel | output | LVL_W | Receive queue occupancy |
| dbgFlags | output | 4 | Sticky bits: 0 tx stall, 1 tx overflow, 2 rx underflow, 3 rx stall |
| dbgClear | input | 4 | Write-one-to-clear strobes for dbgFlags |

## Verification
The hardest situations to reach from the ports are the disabled queue and the mode-change flush. A disabled queue has zero capacity, so its very first access must already count as a stall, an overflow or an underflow. The flush only matters if the queues hold words when the mode changes. To reach both, the stimulus steps through all three join modes in turn. In each mode it fills every queue one word past its capacity and drains it one word past empty, predicting each level and each stall or debug bit from the capacity of that mode. A separate step loads words, flips a join input and checks that the queue is empty one edge later.

// File: rtl/fjp_pkg.sv
package fjp_pkg;

  // effective storage sharing arrangement
  typedef enum logic [1:0] {
    MODE_SPLIT  = 2'd0,
    MODE_TXJOIN = 2'd1,
    MODE_RXJOIN = 2'd2
  } joinMode_t;

  // strobes from control to datapath
  typedef struct packed {
    logic flush;
    logic txWr;
    logic txRd;
    logic rxWr;
    logic rxRd;
  } fjpStrobe_t;

  // debug bit positions
  localparam int DBG_TX_STALL = 0;
  localparam int DBG_TX_OVER  = 1;
  localparam int DBG_RX_UNDER = 2;
  localparam int DBG_RX_STALL = 3;

endpackage

// File: rtl/fjp_ring.sv
module fjp_ring #(
  parameter int PTR_W = 3,
  parameter int CNT_W = PTR_W + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             flush,
  input  logic [CNT_W-1:0] cap,
  input  logic             push,
  input  logic             pop,
  output logic             pushOk,
  output logic             popOk,
  output logic [PTR_W-1:0] rdPtr,
  output logic [PTR_W-1:0] wrPtr,
  output logic [CNT_W-1:0] count,
  output logic             isFull,
  output logic             isEmpty
);

  function automatic logic [PTR_W-1:0] stepPtr(input logic [PTR_W-1:0] p,
                                               input logic [CNT_W-1:0] c);
    logic [CNT_W-1:0] inc;
    inc = CNT_W'(p) + CNT_W'(1);
    return (inc >= c) ? '0 : PTR_W'(inc);
  endfunction

  assign isEmpty = (count == '0);
  assign isFull  = (count == cap);
  assign pushOk  = push && !isFull && !flush;
  assign popOk   = pop && !isEmpty && !flush;

  always_ff @(posedge clk) begin
    if (!rstN || flush) begin
      rdPtr <= '0;
      wrPtr <= '0;
      count <= '0;
    end else begin
      if (pushOk) wrPtr <= stepPtr(wrPtr, cap);
      if (popOk)  rdPtr <= stepPtr(rdPtr, cap);
      count <= count + CNT_W'(pushOk) - CNT_W'(popOk);
    end
  end

  // R2
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    count <= cap);

  // R5
  level_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pushOk && !popOk) |=> (count == $past(count) + CNT_W'(1)));

endmodule

// File: rtl/fjp_ctrl.sv
module fjp_ctrl
  import fjp_pkg::*;
#(
  parameter int BASE_DEPTH = 4,
  parameter int PTR_W      = $clog2(2 * BASE_DEPTH),
  parameter int CNT_W      = PTR_W + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             joinTx,
  input  logic             joinRx,
  input  logic             hostTxPush,
  input  logic             hostRxPop,
  input  logic             engTxPop,
  input  logic             engRxPush,
  input  logic [3:0]       dbgClear,
  output fjpStrobe_t       strb,
  output logic [PTR_W-1:0] txWrIdx,
  output logic [PTR_W-1:0] txRdIdx,
  output logic [PTR_W-1:0] rxWrIdx,
  output logic [PTR_W-1:0] rxRdIdx,
  output logic             txEmpty,
  output logic             txFull,
  output logic             rxEmpty,
  output logic             rxFull,
  output logic [CNT_W-1:0] txCount,
  output logic [CNT_W-1:0] rxCount,
  output logic             engTxStall,
  output logic             engRxStall,
  output logic [3:0]       dbgFlags
);

  localparam logic [CNT_W-1:0] CAP_HALF = CNT_W'(BASE_DEPTH);
  localparam logic [CNT_W-1:0] CAP_FULL = CNT_W'(2 * BASE_DEPTH);
  localparam logic [PTR_W-1:0] UPPER    = PTR_W'(BASE_DEPTH);
  localparam int TX = 0;
  localparam int RX = 1;

  joinMode_t modeReq, modeQ;
  logic      flush;

  assign modeReq = joinTx ? MODE_TXJOIN : (joinRx ? MODE_RXJOIN : MODE_SPLIT);
  assign flush   = (modeReq != modeQ);

  always_ff @(posedge clk) begin
    if (!rstN) modeQ <= MODE_SPLIT;
    else       modeQ <= modeReq;
  end

  // per-direction ring arrays, index 0 transmit, 1 receive
  logic             ringPush   [2];
  logic             ringPop    [2];
  logic             ringPushOk [2];
  logic             ringPopOk  [2];
  logic             ringFull   [2];
  logic             ringEmpty  [2];
  logic [CNT_W-1:0] ringCap    [2];
  logic [CNT_W-1:0] ringCnt    [2];
  logic [PTR_W-1:0] ringBase   [2];
  logic [PTR_W-1:0] ringRd     [2];
  logic [PTR_W-1:0] ringWr     [2];

  always_comb begin
    unique case (modeQ)
      MODE_TXJOIN: begin
        ringCap[TX] = CAP_FULL; ringCap[RX] = '0;
        ringBase[TX] = '0;      ringBase[RX] = '0;
      end
      MODE_RXJOIN: begin
        ringCap[TX] = '0;       ringCap[RX] = CAP_FULL;
        ringBase[TX] = '0;      ringBase[RX] = '0;
      end
      default: begin
        ringCap[TX] = CAP_HALF; ringCap[RX] = CAP_HALF;
        ringBase[TX] = '0;      ringBase[RX] = UPPER;
      end
    endcase
  end

  assign ringPush[TX] = hostTxPush;
  assign ringPop[TX]  = engTxPop;
  assign ringPush[RX] = engRxPush;
  assign ringPop[RX]  = hostRxPop;

  for (genvar g = 0; g < 2; g++) begin : gRing
    fjp_ring #(.PTR_W(PTR_W), .CNT_W(CNT_W)) uRing (
      .clk    (clk),
      .rstN   (rstN),
      .flush  (flush),
      .cap    (ringCap[g]),
      .push   (ringPush[g]),
      .pop    (ringPop[g]),
      .pushOk (ringPushOk[g]),
      .popOk  (ringPopOk[g]),
      .rdPtr  (ringRd[g]),
      .wrPtr  (ringWr[g]),
      .count  (ringCnt[g]),
      .isFull (ringFull[g]),
      .isEmpty(ringEmpty[g])
    );
  end

  assign strb.flush = flush;
  assign strb.txWr  = ringPushOk[TX];
  assign strb.txRd  = ringPopOk[TX];
  assign strb.rxWr  = ringPushOk[RX];
  assign strb.rxRd  = ringPopOk[RX];

  assign txWrIdx = ringBase[TX] + ringWr[TX];
  assign txRdIdx = ringBase[TX] + ringRd[TX];
  assign rxWrIdx = ringBase[RX] + ringWr[RX];
  assign rxRdIdx = ringBase[RX] + ringRd[RX];

  assign txEmpty = ringEmpty[TX];
  assign txFull  = ringFull[TX];
  assign rxEmpty = ringEmpty[RX];
  assign rxFull  = ringFull[RX];
  assign txCount = ringCnt[TX];
  assign rxCount = ringCnt[RX];

  assign engTxStall = engTxPop && ringEmpty[TX];
  assign engRxStall = engRxPush && ringFull[RX];

  logic [3:0] dbgSet;
  always_comb begin
    dbgSet = '0;
    dbgSet[DBG_TX_STALL] = engTxStall;
    dbgSet[DBG_TX_OVER]  = hostTxPush && ringFull[TX];
    dbgSet[DBG_RX_UNDER] = hostRxPop && ringEmpty[RX];
    dbgSet[DBG_RX_STALL] = engRxStall;
  end

  always_ff @(posedge clk) begin
    if (!rstN) dbgFlags <= '0;
    else       dbgFlags <= (dbgFlags & ~dbgClear) | dbgSet;
  end

  // R10
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((dbgFlags & $past(dbgFlags & ~dbgClear)) == $past(dbgFlags & ~dbgClear)));

  // R11
  flush_empty_chk: assert property (@(posedge clk) disable iff (!rstN)
    flush |=> (txEmpty && rxEmpty));

  // R8
  tx_stall_chk: assert property (@(posedge clk) disable iff (!rstN)
    engTxStall |-> !strb.txRd);

  // R9
  rx_stall_chk: assert property (@(posedge clk) disable iff (!rstN)
    engRxStall |-> !strb.rxWr);

endmodule

// File: rtl/fjp_store.sv
module fjp_store
  import fjp_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int BASE_DEPTH = 4,
  parameter int PTR_W      = $clog2(2 * BASE_DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  fjpStrobe_t        strb,
  input  logic [PTR_W-1:0]  txWrIdx,
  input  logic [PTR_W-1:0]  txRdIdx,
  input  logic [PTR_W-1:0]  rxWrIdx,
  input  logic [PTR_W-1:0]  rxRdIdx,
  input  logic [DATA_W-1:0] hostTxData,
  input  logic [DATA_W-1:0] engRxData,
  output logic [DATA_W-1:0] engTxData,
  output logic [DATA_W-1:0] hostRxData
);

  localparam int PHYS_DEPTH = 2 * BASE_DEPTH;

  logic [DATA_W-1:0] mem [PHYS_DEPTH];

  always_ff @(posedge clk) begin
    if (strb.txWr) mem[txWrIdx] <= hostTxData;
    if (strb.rxWr) mem[rxWrIdx] <= engRxData;
  end

  assign engTxData  = strb.txRd ? mem[txRdIdx] : '0;
  assign hostRxData = strb.rxRd ? mem[rxRdIdx] : '0;

  // R3
  distinct_wr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.txWr && strb.rxWr) |-> (txWrIdx != rxWrIdx));

  // R11
  flush_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.flush |-> !(strb.txWr || strb.rxWr || strb.txRd || strb.rxRd));

endmodule

// File: rtl/fifo_join_pair.sv
module fifo_join_pair
  import fjp_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int BASE_DEPTH = 4,
  parameter int LVL_W      = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              joinTx,
  input  logic              joinRx,
  input  logic              hostTxPush,
  input  logic [DATA_W-1:0] hostTxData,
  input  logic              hostRxPop,
  output logic [DATA_W-1:0] hostRxData,
  input  logic              engTxPop,
  output logic [DATA_W-1:0] engTxData,
  output logic              engTxStall,
  input  logic              engRxPush,
  input  logic [DATA_W-1:0] engRxData,
  output logic              engRxStall,
  output logic              txEmpty,
  output logic              txFull,
  output logic              rxEmpty,
  output logic              rxFull,
  output logic [LVL_W-1:0]  txLevel,
  output logic [LVL_W-1:0]  rxLevel,
  output logic [3:0]        dbgFlags,
  input  logic [3:0]        dbgClear
);

  localparam int PTR_W = $clog2(2 * BASE_DEPTH);
  localparam int CNT_W = PTR_W + 1;

  fjpStrobe_t       strb;
  logic [PTR_W-1:0] txWrIdx, txRdIdx, rxWrIdx, rxRdIdx;
  logic [CNT_W-1:0] txCount, rxCount;

  fjp_ctrl #(.BASE_DEPTH(BASE_DEPTH), .PTR_W(PTR_W), .CNT_W(CNT_W)) uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .joinTx    (joinTx),
    .joinRx    (joinRx),
    .hostTxPush(hostTxPush),
    .hostRxPop (hostRxPop),
    .engTxPop  (engTxPop),
    .engRxPush (engRxPush),
    .dbgClear  (dbgClear),
    .strb      (strb),
    .txWrIdx   (txWrIdx),
    .txRdIdx   (txRdIdx),
    .rxWrIdx   (rxWrIdx),
    .rxRdIdx   (rxRdIdx),
    .txEmpty   (txEmpty),
    .txFull    (txFull),
    .rxEmpty   (rxEmpty),
    .rxFull    (rxFull),
    .txCount   (txCount),
    .rxCount   (rxCount),
    .engTxStall(engTxStall),
    .engRxStall(engRxStall),
    .dbgFlags  (dbgFlags)
  );

  fjp_store #(.DATA_W(DATA_W), .BASE_DEPTH(BASE_DEPTH), .PTR_W(PTR_W)) uStore (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .txWrIdx   (txWrIdx),
    .txRdIdx   (txRdIdx),
    .rxWrIdx   (rxWrIdx),
    .rxRdIdx   (rxRdIdx),
    .hostTxData(hostTxData),
    .engRxData (engRxData),
    .engTxData (engTxData),
    .hostRxData(hostRxData)
  );

  assign txLevel = LVL_W'(txCount);
  assign rxLevel = LVL_W'(rxCount);

endmodule

// File: tb/sim_fifo_join_pair.sv
module sim_fifo_join_pair;

  localparam int DW = 32;
  localparam int BD = 4;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          joinTx = 1'b0, joinRx = 1'b0;
  logic          hostTxPush = 1'b0, hostRxPop = 1'b0;
  logic          engTxPop = 1'b0, engRxPush = 1'b0;
  logic [DW-1:0] hostTxData = '0, engRxData = '0;
  logic [DW-1:0] hostRxData, engTxData;
  logic          engTxStall, engRxStall;
  logic          txEmpty, txFull, rxEmpty, rxFull;
  logic [3:0]    txLevel, rxLevel, dbgFlags;
  logic [3:0]    dbgClear = '0;

  int nChecks = 0;
  int nFails  = 0;

  always #5 clk = ~clk;

  fifo_join_pair #(.DATA_W(DW), .BASE_DEPTH(BD), .LVL_W(4)) u0 (
    .clk(clk), .rstN(rstN), .joinTx(joinTx), .joinRx(joinRx),
    .hostTxPush(hostTxPush), .hostTxData(hostTxData),
    .hostRxPop(hostRxPop), .hostRxData(hostRxData),
    .engTxPop(engTxPop), .engTxData(engTxData), .engTxStall(engTxStall),
    .engRxPush(engRxPush), .engRxData(engRxData), .engRxStall(engRxStall),
    .txEmpty(txEmpty), .txFull(txFull), .rxEmpty(rxEmpty), .rxFull(rxFull),
    .txLevel(txLevel), .rxLevel(rxLevel),
    .dbgFlags(dbgFlags), .dbgClear(dbgClear)
  );

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finishUp();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  endtask

  // advance one edge, land 2 ns after it
  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic idle();
    hostTxPush = 0; hostRxPop = 0; engTxPop = 0; engRxPush = 0; dbgClear = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual hung expected done");
    finishUp();
  end

  initial begin
    int txCap, rxCap, expLvl;
    logic [3:0] expFlags;
    repeat (3) @(posedge clk);
    #2;
    // R1 reset state
    chk("R1 txEmpty", txEmpty, 1);
    chk("R1 rxEmpty", rxEmpty, 1);
    chk("R1 txFull", txFull, 0);
    chk("R1 rxFull", rxFull, 0);
    chk("R1 levels", {txLevel, rxLevel}, 0);
    chk("R1 flags", dbgFlags, 0);
    rstN = 1;
    step();

    // sweep over modes: 0 split (R2), 1 tx joined (R3), 2 rx joined (R4)
    for (int mode = 0; mode < 3; mode++) begin
      joinTx = (mode == 1);
      joinRx = (mode == 2);
      step();
      dbgClear = 4'hF;
      step();
      idle();
      txCap = (mode == 1) ? 2 * BD : (mode == 2) ? 0 : BD;
      rxCap = (mode == 2) ? 2 * BD : (mode == 1) ? 0 : BD;
      chk("R11 tx level after mode change", txLevel, 0);
      chk("R11 rx level after mode change", rxLevel, 0);
      chk("R3 R4 rx full when disabled", rxFull, (rxCap == 0));
      chk("R3 R4 tx full when disabled", txFull, (txCap == 0));
      chk("R10 flags cleared", dbgFlags, 0);
      expFlags = 4'b0000;

      // transmit fill, one word past capacity (R6)
      for (int i = 0; i <= txCap; i++) begin
        hostTxPush = 1; hostTxData = 32'h100 * mode + i + 32'hA000;
        step();
        idle();
        expLvl = (i + 1 < txCap) ? i + 1 : txCap;
        chk("R2 R3 R4 R5 tx level", txLevel, expLvl);
        chk("R2 tx full", txFull, (expLvl == txCap));
        chk("R2 tx empty", txEmpty, (expLvl == 0));
      end
      expFlags[1] = 1'b1;
      chk("R6 tx overflow flag", dbgFlags, expFlags);

      // transmit drain, one past empty (R8)
      for (int i = 0; i <= txCap; i++) begin
        engTxPop = 1;
        #1;
        chk("R8 tx stall strobe", engTxStall, (i == txCap));
        chk("R2 R3 tx data order", engTxData,
            (i < txCap) ? (32'h100 * mode + i + 32'hA000) : 32'h0);
        step();
        idle();
        chk("R5 tx level drain", txLevel, txCap - ((i + 1 < txCap) ? i + 1 : txCap));
      end
      expFlags[0] = 1'b1;
      chk("R8 tx stall flag", dbgFlags, expFlags);

      // receive fill, one past capacity (R9)
      for (int i = 0; i <= rxCap; i++) begin
        engRxPush = 1; engRxData = 32'h100 * mode + i + 32'h5000;
        #1;
        chk("R9 rx stall strobe", engRxStall, (i == rxCap));
        step();
        idle();
        expLvl = (i + 1 < rxCap) ? i + 1 : rxCap;
        chk("R2 R4 R5 rx level", rxLevel, expLvl);
        chk("R2 rx full", rxFull, (expLvl == rxCap));
      end
      expFlags[3] = 1'b1;
      chk("R9 rx stall flag", dbgFlags, expFlags);

      // receive drain, one past empty (R7)
      for (int i = 0; i <= rxCap; i++) begin
        hostRxPop = 1;
        #1;
        chk("R2 R4 R7 rx data", hostRxData,
            (i < rxCap) ? (32'h100 * mode + i + 32'h5000) : 32'h0);
        step();
        idle();
        chk("R7 rx level", rxLevel, rxCap - ((i + 1 < rxCap) ? i + 1 : rxCap));
        chk("R7 rx empty", rxEmpty, 1'((i + 1) >= rxCap));
      end
      expFlags[2] = 1'b1;
      chk("R7 rx underflow flag", dbgFlags, expFlags);

      // R10 partial write-one-to-clear, then writing zero
      dbgClear = 4'b0101;
      step();
      idle();
      chk("R10 partial clear", dbgFlags, 4'b1010);
      step();
      chk("R10 zero write keeps", dbgFlags, 4'b1010);
    end

    // R4 both joins set: transmit join wins
    joinTx = 1; joinRx = 1;
    step();
    step();
    chk("R4 both joins rx disabled", {rxEmpty, rxFull}, 2'b11);
    chk("R4 both joins tx usable", {txEmpty, txFull}, 2'b10);

    // back to split, R5 simultaneous push and pop
    joinTx = 0; joinRx = 0;
    step();
    for (int i = 0; i < 2; i++) begin
      hostTxPush = 1; hostTxData = 32'hC0 + i;
      step();
    end
    for (int i = 2; i < 8; i++) begin
      hostTxPush = 1; hostTxData = 32'hC0 + i; engTxPop = 1;
      #1;
      chk("R5 order under concurrent push pop", engTxData, 32'hC0 + i - 2);
      step();
      chk("R5 level steady", txLevel, 2);
    end
    idle();

    // R11 flush with stored data, plus rx contents
    engRxPush = 1; engRxData = 32'h77;
    step();
    idle();
    chk("R11 rx loaded", rxLevel, 1);
    joinRx = 1;
    step();
    chk("R11 tx flushed", {txLevel, txEmpty}, 5'b0000_1);
    chk("R11 rx flushed", {rxLevel, rxEmpty}, 5'b0000_1);
    joinRx = 0;
    step();

    // R10 set wins over clear in the same cycle
    dbgClear = 4'hF;
    step();
    engTxPop = 1; dbgClear = 4'b0001;
    step();
    idle();
    chk("R10 set beats clear", dbgFlags, 4'b0001);

    finishUp();
  end

endmodule